// File: doc/BRIEF.md
# USB Host Interrupt Request Combiner

This block merges four host-controller status conditions into a single interrupt request line. Each condition has a sticky status bit and an enable bit. The sticky bit is set by a one-cycle hardware event pulse. Software clears it by writing a one to it. The four conditions are:

- a transfer-complete event
- a bus error event
- a port status change
- a periodic-list wrap

Two of the sources act at once: the port change and the list wrap pull the request line high as soon as the status bit and the enable bit are both set. The list wrap counts only while the controller runs as a host. The other two sources, transfer-complete and bus error, are deferred. Each one waits for a threshold tick, which comes from a counter outside this block. When a deferred source is set and enabled at a tick, it latches a pending flag. That flag keeps the line asserted until software clears the status bit or removes the enable.

Software reaches both registers through a 32-bit single-cycle register port. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. There is no handshake and no back-pressure: every access completes in the cycle it is presented. The event and tick pins are plain control inputs.

Top module: `usbh_irq_ctrl`

## Requirements
- R1: After reset the status register, the enable register and `irq` are all zero.
- R2: A one-cycle pulse on an event input sets its sticky status bit at that clock edge. The status register is at word address 0, with transfer-complete in bit 0, bus error in bit 1, port change in bit 2 and list wrap in bit 3.
- R3: Writing the status address clears each bit written as one and leaves bits written as zero unchanged. When an event pulse and a clear of the same bit occur in the same cycle, the bit stays set.
- R4: The enable register is at word address 1 and uses the same bit positions as the status register. It reads back what was written in bits 3:0. Bits 31:4 of both registers read as zero and ignore writes.
- R5: When the port change status bit and its enable are both one, `irq` is high one clock edge later.
- R6: When the list wrap status bit and its enable are both one, `irq` is high one clock edge later, but only while `host_mode` is high.
- R7: A deferred source (bit 0 or bit 1) never raises `irq` on its own. A threshold tick that is sampled while that source's status bit and enable bit are both one latches a pending flag, and `irq` rises one edge after that. A tick that is sampled while the source is not enabled has no effect.
- R8: A latched pending flag keeps `irq` asserted for as long as its status bit stays set and its enable bit is one. Clearing the status bit discards the flag.
- R9: A read of any address other than 0 or 1 returns zero. A write to such an address changes neither register.
- R10: `irq` falls one clock edge after the last qualified source goes away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_mode | input | 1 | High when the controller runs as a host; gates the list-wrap source |
| ev_xfer | input | 1 | Transfer-complete event pulse |
| ev_err | input | 1 | Bus error event pulse |
| ev_port | input | 1 | Port change event pulse |
| ev_roll | input | 1 | Periodic-list wrap event pulse |
| thr_tick | input | 1 | Interrupt threshold boundary pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume three things about the inputs:

- Event and tick inputs are driven synchronously to `clk`.
- Every input holds a known value once reset is released.
- A pending flag exists only for a status bit that is still set.

The bench changes every input just after a falling edge and samples just before the next rising edge, so each stimulus lands on exactly one rising edge. Event pulses and ticks last one cycle. The sweep clears both registers before each pattern, so a pending flag left over from one pattern cannot leak into the next. Collisions between an event and a clear are produced only in directed cases.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
  localparam int NSRC     = 4;
  localparam int SRC_XFER = 0;
  localparam int SRC_ERR  = 1;
  localparam int SRC_PORT = 2;
  localparam int SRC_ROLL = 3;

  typedef logic [NSRC-1:0] src_vec_t;

  // sources that wait for a threshold tick
  localparam src_vec_t DEFER_SET = 4'b0011;
  // sources that count only in host operation
  localparam src_vec_t HOST_ONLY = 4'b1000;
endpackage

// File: rtl/irq_regport.sv
module irq_regport
  import usbh_irq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int STATUS_ADDR = 0,
  parameter int ENABLE_ADDR = 1
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  src_vec_t          status_q,
  input  src_vec_t          enable_q,
  output logic              en_we,
  output src_vec_t          en_wdata,
  output src_vec_t          st_clr,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(STATUS_ADDR);
  localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(ENABLE_ADDR);

  logic hit_st, hit_en;
  logic unused_hi;

  assign hit_st    = (reg_addr == A_ST);
  assign hit_en    = (reg_addr == A_EN);
  assign unused_hi = ^reg_wdata[DATA_W-1:NSRC];

  always_comb begin
    en_we    = reg_wr && hit_en;
    en_wdata = reg_wdata[NSRC-1:0];
    st_clr   = (reg_wr && hit_st) ? reg_wdata[NSRC-1:0] : '0;
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_st)      reg_rdata[NSRC-1:0] = status_q;
    else if (hit_en) reg_rdata[NSRC-1:0] = enable_q;
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import usbh_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  src_vec_t clr_vec,
  input  logic     en_we,
  input  src_vec_t en_wdata,
  output src_vec_t status_q,
  output src_vec_t status_nx,
  output src_vec_t enable_q
);
  // a set in the same cycle overrides a clear
  assign status_nx = (status_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_nx;
      if (en_we) enable_q <= en_wdata;
    end
  end
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
  import usbh_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     host_mode,
  input  logic     thr_tick,
  input  src_vec_t status_q,
  input  src_vec_t status_nx,
  input  src_vec_t enable_q,
  output src_vec_t pend_q,
  output logic     irq
);
  src_vec_t qual;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (DEFER_SET[i]) begin : g_defer
      logic p_r;
      always_ff @(posedge clk) begin
        if (!rst_n) p_r <= 1'b0;
        else        p_r <= status_nx[i] &
                           (p_r | (thr_tick & status_q[i] & enable_q[i]));
      end
      assign pend_q[i] = p_r;
      assign qual[i]   = p_r & enable_q[i];
    end else if (HOST_ONLY[i]) begin : g_host
      assign pend_q[i] = 1'b0;
      assign qual[i]   = status_q[i] & enable_q[i] & host_mode;
    end else begin : g_now
      assign pend_q[i] = 1'b0;
      assign qual[i]   = status_q[i] & enable_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |qual;
  end
endmodule

// File: rtl/usbh_irq_ctrl.sv
module usbh_irq_ctrl
  import usbh_irq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int STATUS_ADDR = 0,
  parameter int ENABLE_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              ev_xfer,
  input  logic              ev_err,
  input  logic              ev_port,
  input  logic              ev_roll,
  input  logic              thr_tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  src_vec_t set_vec, st_clr, en_wdata;
  src_vec_t status_q, status_nx, enable_q, pend_q;
  logic     en_we;

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_XFER] = ev_xfer;
    set_vec[SRC_ERR]  = ev_err;
    set_vec[SRC_PORT] = ev_port;
    set_vec[SRC_ROLL] = ev_roll;
  end

  irq_regport #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .STATUS_ADDR(STATUS_ADDR), .ENABLE_ADDR(ENABLE_ADDR)
  ) u_port (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status_q(status_q), .enable_q(enable_q),
    .en_we(en_we), .en_wdata(en_wdata), .st_clr(st_clr),
    .reg_rdata(reg_rdata)
  );

  irq_status_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(st_clr),
    .en_we(en_we), .en_wdata(en_wdata),
    .status_q(status_q), .status_nx(status_nx), .enable_q(enable_q)
  );

  irq_qualify u_qual (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .thr_tick(thr_tick),
    .status_q(status_q), .status_nx(status_nx), .enable_q(enable_q),
    .pend_q(pend_q), .irq(irq)
  );
endmodule

// File: rtl/usbh_irq_chk.sv
module usbh_irq_chk
  import usbh_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_mode,
  input logic              ev_port,
  input logic              irq,
  input logic [DATA_W-1:0] reg_rdata,
  input src_vec_t          status_q,
  input src_vec_t          enable_q,
  input src_vec_t          pend_q
);
  logic     imm_cause;
  src_vec_t pend_live;

  assign imm_cause = (status_q[SRC_PORT] & enable_q[SRC_PORT]) |
                     (status_q[SRC_ROLL] & enable_q[SRC_ROLL] & host_mode);
  assign pend_live = pend_q & enable_q;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!irq && status_q == '0 && enable_q == '0));

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_port |=> status_q[SRC_PORT]);

  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:NSRC] == '0);

  p_port_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[SRC_PORT] && enable_q[SRC_PORT]) |=> irq);

  p_wrap_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[SRC_ROLL] && enable_q[SRC_ROLL] && host_mode) |=> irq);

  p_rise_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(imm_cause || (pend_live != '0)));

  p_pend_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~status_q) == '0);

  p_drop_no_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_cause && pend_live == '0) |=> !irq);
endmodule

bind usbh_irq_ctrl usbh_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .ev_port(ev_port),
  .irq(irq), .reg_rdata(reg_rdata), .status_q(status_q),
  .enable_q(enable_q), .pend_q(pend_q)
);

// File: tb/sim_usbh_irq_ctrl.sv
module sim_usbh_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_mode = 1'b0;
  logic        ev_xfer = 1'b0, ev_err = 1'b0, ev_port = 1'b0, ev_roll = 1'b0;
  logic        thr_tick = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  usbh_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
    .ev_xfer(ev_xfer), .ev_err(ev_err), .ev_port(ev_port), .ev_roll(ev_roll),
    .thr_tick(thr_tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [1:0] a,
                    input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse_ev(input logic [3:0] s);
    {ev_roll, ev_port, ev_err, ev_xfer} = s;
    cyc();
    {ev_roll, ev_port, ev_err, ev_xfer} = '0;
  endtask

  task automatic tick();
    thr_tick = 1'b1;
    cyc();
    thr_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd("R1 status", 2'd0, 32'h0);
    rd("R1 enable", 2'd1, 32'h0);
    rst_n = 1'b1;
    cyc();

    // R4 enable readback, reserved bits
    wr(2'd1, 32'hFFFF_FFFF);
    rd("R4 enable reserved", 2'd1, 32'h0000_000F);
    wr(2'd1, 32'h0000_0005);
    rd("R4 enable value", 2'd1, 32'h0000_0005);

    // R9 unmapped address
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd("R9 read addr2", 2'd2, 32'h0);
    rd("R9 read addr3", 2'd3, 32'h0);
    rd("R9 enable untouched", 2'd1, 32'h5);
    rd("R9 status untouched", 2'd0, 32'h0);
    wr(2'd1, 32'h0);

    // R3 set wins over clear; write of zero leaves bits
    pulse_ev(4'b0100);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h4; ev_port = 1'b1;
    cyc();
    reg_wr = 1'b0; reg_wdata = '0; ev_port = 1'b0;
    rd("R3 set wins", 2'd0, 32'h4);
    wr(2'd0, 32'h0);
    rd("R3 zero write keeps", 2'd0, 32'h4);
    wr(2'd0, 32'h4);
    rd("R3 one write clears", 2'd0, 32'h0);

    // R7 tick before enable is ignored
    pulse_ev(4'b0010);
    tick();
    wr(2'd1, 32'h2);
    cyc(); cyc();
    chk("R7 stale tick ignored", {31'b0, irq}, 32'h0);
    tick();
    cyc();
    chk("R7 tick raises", {31'b0, irq}, 32'h1);

    // R8 enable removal drops, pending kept while status set
    wr(2'd1, 32'h0);
    cyc();
    chk("R8 disable drops", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h2);
    cyc();
    chk("R8 pending held", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h2);
    cyc();
    chk("R10 clear drops", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h0);

    // exhaustive sweep: host_mode x enable x status
    for (int hm = 0; hm < 2; hm++) begin
      for (int e = 0; e < 16; e++) begin
        for (int s = 0; s < 16; s++) begin
          logic [3:0] ev, sv;
          logic imm, def;
          ev = 4'(e); sv = 4'(s);
          imm = (sv[2] & ev[2]) | (sv[3] & ev[3] & hm[0]);
          def = |(sv[1:0] & ev[1:0]);
          host_mode = hm[0];
          wr(2'd1, 32'h0);
          wr(2'd0, 32'hF);
          cyc();
          wr(2'd1, {28'b0, ev});
          pulse_ev(sv);
          cyc();
          chk(hm[0] ? "R5/R6 immediate host" : "R5/R6 immediate dev",
              {31'b0, irq}, {31'b0, imm});
          rd("R2 status", 2'd0, {28'b0, sv});
          rd("R4 enable", 2'd1, {28'b0, ev});
          cyc();
          chk("R7 no early deferred", {31'b0, irq}, {31'b0, imm});
          tick();
          cyc();
          chk("R7 after tick", {31'b0, irq}, {31'b0, imm | def});
          wr(2'd0, 32'hF);
          cyc();
          chk("R10 after clear", {31'b0, irq}, 32'h0);
          rd("R3 cleared", 2'd0, 32'h0);
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule